// File: doc/BRIEF.md
# Lockable Averaging Bit Slicer

This block sets the decision level that turns signed soft samples from a demodulator into hard bits. On each baud strobe it compares the new sample with the current threshold to produce a bit. It then folds the sample into a moving sum over the last 2^WIN_LOG2 accepted bauds. The threshold is that sum shifted right, so no divider is needed.

The threshold can be frozen. In manual mode the lock request freezes it on the next clock. In automatic mode the block freezes it by itself once a settling count of bauds has gone by since the last restart. That count is set by a 2-bit settling code. Automatic lock does not look at the data: it assumes a DC-balanced preamble came first.

Once frozen, the threshold stays unchanged for as long as the lock request stays high, whatever the samples are, so long runs of equal bits do not pull the level. Dropping the lock request while frozen releases the lock. The release clears the baud count, and averaging starts again, empty, from the next strobe.

Top module: `baud_slicer`

## Requirements
- R1: During and after synchronous reset, bit_o is 0, thresh_o is 0, and filled_o and locked_o are both 0.
- R2: The clock edge that samples baud_stb_i high loads bit_o with 1 if sample_i (two's complement) is greater than or equal to the threshold held before that edge, and with 0 otherwise. A tie gives 1.
- R3: While unlocked, each strobe that is accepted updates thresh_o at the same edge. The new value is floor(S/16), where S is the signed sum of the last min(n,16) accepted samples since reset or restart and n is the number of those samples (window 2^WIN_LOG2 = 16).
- R4: filled_o rises at the edge of the 11th accepted baud after reset or restart, and stays high until the next restart.
- R5: With auto_lock_i=1 and lock_req_i=1, locked_o rises at the edge of the accepted baud that brings the accepted count to 11 + (3 << settle_sel_i): 14, 17, 23 or 35 for codes 00 to 11. That baud still updates the threshold. With lock_req_i=0 no automatic lock happens.
- R6: With auto_lock_i=0, lock_req_i=1 locks the block at the next clock edge. A strobe that arrives in that same cycle is not averaged.
- R7: While locked_o=1 and lock_req_i stays 1, thresh_o does not change. This holds for any sample values, any run length of equal bits, and any change of auto_lock_i or settle_sel_i.
- R8: Driving lock_req_i low while locked clears locked_o and filled_o at the next edge. The average then restarts empty, and the following strobes are averaged as in R3 counting from zero.
- R9: Without a strobe, bit_o and thresh_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_stb_i | input | 1 | One-cycle strobe marking a new baud sample |
| sample_i | input | SAMPLE_W | Signed soft sample |
| lock_req_i | input | 1 | Lock request (manual) or lock enable (automatic); low releases |
| auto_lock_i | input | 1 | 1 = lock after settling count, 0 = lock on request |
| settle_sel_i | input | 2 | Settling code for automatic lock |
| bit_o | output | 1 | Sliced bit |
| thresh_o | output | SAMPLE_W | Current signed decision threshold |
| filled_o | output | 1 | Averaging filter has seen enough bauds |
| locked_o | output | 1 | Threshold frozen |

## Verification
The sliced bit, the threshold and filled_o all come from the edge that samples the strobe, so each baud's results are read at the falling edge right after that rising edge. The bench drives the strobe half a cycle earlier. A manual lock or a release shows on locked_o one edge after lock_req_i changes. An automatic lock shows at the edge of the strobe that reaches the settling count. The bench therefore keeps lock changes and strobes in separate cycles and compares every output against its own arithmetic model after each step. Idle stretches without strobes are checked cycle by cycle for stable outputs.

// File: rtl/baud_slicer_pkg.sv
package baud_slicer_pkg;
  // bauds needed before automatic lock: fill + (sync << code)
  function automatic int settle_target(input int fill, input int sync, input logic [1:0] code);
    return fill + (sync << code);
  endfunction
endpackage

// File: rtl/baud_slicer_window.sv
module baud_slicer_window #(
  parameter int SAMPLE_W = 8,
  parameter int WIN_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_i,
  input  logic                       push_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  output logic signed [SAMPLE_W-1:0] avg_next_o
);
  localparam int DEPTH = 1 << WIN_LOG2;
  localparam int SUM_W = SAMPLE_W + WIN_LOG2;

  // sample history, no reset so it maps to RAM
  logic signed [SAMPLE_W-1:0] hist_mem [DEPTH];
  logic [WIN_LOG2-1:0]        wr_ptr_q;
  logic [WIN_LOG2:0]          occ_q;
  logic signed [SUM_W-1:0]    sum_q, sum_next, new_ext, old_ext;

  always_ff @(posedge clk) begin
    if (push_i) hist_mem[wr_ptr_q] <= sample_i;
  end

  always_comb begin
    new_ext = {{WIN_LOG2{sample_i[SAMPLE_W-1]}}, sample_i};
    if (occ_q[WIN_LOG2])
      old_ext = {{WIN_LOG2{hist_mem[wr_ptr_q][SAMPLE_W-1]}}, hist_mem[wr_ptr_q]};
    else
      old_ext = '0;
    sum_next = sum_q + new_ext - old_ext;
  end

  // arithmetic shift right by WIN_LOG2 == upper slice of the sum
  assign avg_next_o = sum_next[SUM_W-1:WIN_LOG2];

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sum_q    <= '0;
      occ_q    <= '0;
      wr_ptr_q <= '0;
    end else if (push_i) begin
      sum_q    <= sum_next;
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (!occ_q[WIN_LOG2]) occ_q <= occ_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_slicer_lockctl.sv
module baud_slicer_lockctl
  import baud_slicer_pkg::*;
#(
  parameter int FILL_BAUDS = 11,
  parameter int SYNC_BAUDS = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb_i,
  input  logic       req_i,
  input  logic       auto_i,
  input  logic [1:0] sel_i,
  output logic       accept_o,
  output logic       clear_o,
  output logic       locked_o,
  output logic       filled_o
);
  localparam int TGT_MAX = FILL_BAUDS + (SYNC_BAUDS << 3);
  localparam int CNT_W   = $clog2(TGT_MAX + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             locked_q, filled_q;
  logic             lock_man, unlock_now, auto_hit, accept;

  always_comb begin
    lock_man   = !locked_q && req_i && !auto_i;
    unlock_now = locked_q && !req_i;
    accept     = stb_i && !locked_q && !lock_man;
    cnt_inc    = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    auto_hit   = accept && auto_i && req_i &&
                 (int'(cnt_inc) >= settle_target(FILL_BAUDS, SYNC_BAUDS, sel_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      filled_q <= 1'b0;
    end else if (unlock_now) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
      filled_q <= 1'b0;
    end else begin
      if (lock_man || auto_hit) locked_q <= 1'b1;
      if (accept) begin
        cnt_q    <= cnt_inc;
        filled_q <= int'(cnt_inc) >= FILL_BAUDS;
      end
    end
  end

  assign accept_o = accept;
  assign clear_o  = unlock_now;
  assign locked_o = locked_q;
  assign filled_o = filled_q;
endmodule

// File: rtl/baud_slicer_decide.sv
module baud_slicer_decide #(
  parameter int SAMPLE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stb_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic signed [SAMPLE_W-1:0] thresh_i,
  output logic                       bit_o
);
  always_ff @(posedge clk) begin
    if (rst)        bit_o <= 1'b0;
    else if (stb_i) bit_o <= (sample_i >= thresh_i);
  end
endmodule

// File: rtl/baud_slicer.sv
module baud_slicer #(
  parameter int SAMPLE_W   = 8,
  parameter int WIN_LOG2   = 4,
  parameter int FILL_BAUDS = 11,
  parameter int SYNC_BAUDS = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_stb_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                lock_req_i,
  input  logic                auto_lock_i,
  input  logic [1:0]          settle_sel_i,
  output logic                bit_o,
  output logic [SAMPLE_W-1:0] thresh_o,
  output logic                filled_o,
  output logic                locked_o
);
  logic                       accept, clear;
  logic signed [SAMPLE_W-1:0] avg_next, thresh_q, sample_s;

  assign sample_s = $signed(sample_i);

  baud_slicer_lockctl #(.FILL_BAUDS(FILL_BAUDS), .SYNC_BAUDS(SYNC_BAUDS)) lockctl_i (
    .clk(clk), .rst(rst), .stb_i(baud_stb_i), .req_i(lock_req_i),
    .auto_i(auto_lock_i), .sel_i(settle_sel_i),
    .accept_o(accept), .clear_o(clear), .locked_o(locked_o), .filled_o(filled_o)
  );

  baud_slicer_window #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) window_i (
    .clk(clk), .rst(rst), .clr_i(clear), .push_i(accept),
    .sample_i(sample_s), .avg_next_o(avg_next)
  );

  baud_slicer_decide #(.SAMPLE_W(SAMPLE_W)) decide_i (
    .clk(clk), .rst(rst), .stb_i(baud_stb_i),
    .sample_i(sample_s), .thresh_i(thresh_q), .bit_o(bit_o)
  );

  // threshold register: follows accepted bauds, holds through lock and restart
  always_ff @(posedge clk) begin
    if (rst)         thresh_q <= '0;
    else if (accept) thresh_q <= avg_next;
  end

  assign thresh_o = thresh_q;
endmodule

// File: rtl/baud_slicer_chk.sv
module baud_slicer_chk #(
  parameter int SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                baud_stb_i,
  input logic                lock_req_i,
  input logic                auto_lock_i,
  input logic                bit_o,
  input logic [SAMPLE_W-1:0] thresh_o,
  input logic                filled_o,
  input logic                locked_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (thresh_o == '0 && !bit_o && !filled_o && !locked_o));

  // R4
  fill_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(filled_o) |-> $past(baud_stb_i));

  // R5
  auto_lock_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) && $past(auto_lock_i) |-> $past(baud_stb_i) && $past(lock_req_i));

  // R6
  manual_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_lock_i && lock_req_i && !locked_o |=> locked_o);

  // R7
  frozen_level_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o && lock_req_i |=> locked_o && $stable(thresh_o));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o && !lock_req_i |=> !locked_o && !filled_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !baud_stb_i |=> $stable(thresh_o) && $stable(bit_o));
endmodule

bind baud_slicer baud_slicer_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rst(rst), .baud_stb_i(baud_stb_i), .lock_req_i(lock_req_i),
  .auto_lock_i(auto_lock_i), .bit_o(bit_o), .thresh_o(thresh_o),
  .filled_o(filled_o), .locked_o(locked_o)
);

// File: tb/baud_slicer_tb.sv
module baud_slicer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stb = 1'b0;
  logic [7:0] sample = '0;
  logic       req = 1'b0;
  logic       auto_m = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       bit_o, filled_o, locked_o;
  logic [7:0] thresh_o;

  always #10 clk = ~clk;

  baud_slicer dut_i (
    .clk(clk), .rst(rst), .baud_stb_i(stb), .sample_i(sample),
    .lock_req_i(req), .auto_lock_i(auto_m), .settle_sel_i(sel),
    .bit_o(bit_o), .thresh_o(thresh_o), .filled_o(filled_o), .locked_o(locked_o)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;

  // model state
  int m_win[$];
  int m_thr = 0, m_bit = 0, m_cnt = 0;
  bit m_fill = 1'b0, m_lock = 1'b0;
  int unsigned seed = 32'd7;

  task automatic check(input string tag, input string what, input int got, input int exp);
    vecs++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string ttag, input string ltag);
    check("R2", "bit", int'(bit_o), m_bit);
    check(ttag, "thresh", int'($signed(thresh_o)), m_thr);
    check("R4", "filled", int'(filled_o), int'(m_fill));
    check(ltag, "locked", int'(locked_o), int'(m_lock));
  endtask

  function automatic int next_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) % 201) - 100;
  endfunction

  task automatic baud(input int s, input string ltag);
    int sum;
    string ttag;
    ttag = m_lock ? "R7" : "R3";
    @(negedge clk);
    sample = s[7:0];
    stb = 1'b1;
    m_bit = (s >= m_thr) ? 1 : 0;
    if (!m_lock) begin
      m_win.push_back(s);
      if (m_win.size() > 16) void'(m_win.pop_front());
      sum = 0;
      foreach (m_win[k]) sum += m_win[k];
      m_thr = sum >>> 4;
      if (m_cnt < 63) m_cnt++;
      if (m_cnt >= 11) m_fill = 1'b1;
      if (auto_m && req && m_cnt >= 11 + (3 << sel)) m_lock = 1'b1;
    end
    @(negedge clk);
    stb = 1'b0;
    check_all(ttag, ltag);
  endtask

  task automatic set_req(input bit v);
    string ltag;
    @(negedge clk);
    req = v;
    ltag = "R6";
    if (v && !auto_m && !m_lock) m_lock = 1'b1;
    else if (!v && m_lock) begin
      m_lock = 1'b0; m_fill = 1'b0; m_cnt = 0; m_win.delete();
      ltag = "R8";
    end
    @(negedge clk);
    check_all(m_lock ? "R7" : "R9", ltag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all("R9", "R9");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1", "R1");
    rst = 1'b0;
    idle(2);

    // automatic lock for every settling code
    for (int c = 0; c < 4; c++) begin
      int off;
      int tgt;
      off = c * 7 - 10;
      tgt = 11 + (3 << c);
      auto_m = 1'b1;
      sel = c[1:0];
      set_req(1'b0);
      set_req(1'b1);
      for (int i = 0; i < tgt + 3; i++) baud((i % 2) ? off + 50 : off - 50, "R5");
      check("R5", "locked after settling", int'(locked_o), 1);
      for (int i = 0; i < 30; i++) baud(100, "R7");
      idle(4);
    end

    // manual mode: release, track, lock, long run
    auto_m = 1'b0;
    set_req(1'b0);
    for (int i = 0; i < 20; i++) baud(next_rand(), "R6");
    baud(m_thr, "R2");
    set_req(1'b1);
    for (int i = 0; i < 30; i++) baud(-120, "R7");
    auto_m = 1'b1;
    sel = 2'd3;
    for (int i = 0; i < 10; i++) baud(127, "R7");
    auto_m = 1'b0;
    set_req(1'b0);
    for (int i = 0; i < 5; i++) baud(60 + i, "R8");
    for (int i = 0; i < 25; i++) baud(next_rand(), "R8");
    baud(m_thr, "R2");
    baud(m_thr - 1, "R2");

    // automatic mode with request low: tracks, no lock
    auto_m = 1'b1;
    sel = 2'd0;
    for (int i = 0; i < 30; i++) baud(next_rand(), "R5");
    idle(3);
    // request raised after count passed target: locks on next baud
    set_req(1'b1);
    baud(-30, "R5");
    check("R5", "late enable lock", int'(locked_o), 1);
    baud(90, "R7");
    idle(3);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule